// File: doc/BRIEF.md
# Packed Four-Lane SIMD Arithmetic Unit

This unit treats each 64-bit operand as four signed 16-bit lanes and carries out one of four packed operations per accepted request: a lane-by-lane add, an add of one broadcast 16-bit scalar to every lane, a widening multiply that turns four 16-bit lane pairs into four exact 32-bit products, and a horizontal sum of the lanes of operand A that is folded into a persistent 40-bit accumulator. The two add forms can either wrap or clamp on overflow, chosen per request.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream through a single output register. A request is accepted in a cycle where `in_valid` and `in_ready` are both high. The result appears one cycle later with `out_valid` high. It stays put while `out_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in that same cycle, so a consumer that holds `out_ready` high sees one result per cycle. The accumulator is also visible on its own plain output, and a plain synchronous clear pin resets it.

Top module: `simd_pack_alu`

## Requirements
- R1: With `in_op` = 2'b00 (lane add) and `in_sat` low, result lane k (bits [16k+15:16k], lane 0 at bits [15:0]) equals lane k of A plus lane k of B modulo 2^16, and result bits [127:64] are zero.
- R2: With `in_sat` high, an add lane whose signed sum exceeds 32767 gives 16'h7FFF, and one whose sum is below -32768 gives 16'h8000; lanes that fit are unchanged from R1.
- R3: With `in_op` = 2'b10 (scalar add), `in_scalar` is added to every lane of A, with wrap or clamp as in R1/R2 and bits [127:64] zero.
- R4: With `in_op` = 2'b01 (widening multiply), result bits [32k+31:32k] hold the exact signed 32-bit product of lane k of A and lane k of B.
- R5: With `in_op` = 2'b11 (reduce), the signed sum of the four lanes of A, sign-extended to 40 bits, is added modulo 2^40 to the accumulator. The result carries the new accumulator value sign-extended to 128 bits.
- R6: `acc_clr` high at a clock edge zeroes the accumulator. If a reduce is accepted at the same edge, the accumulator becomes that reduce's sum alone. Otherwise the accumulator only changes on an accepted reduce.
- R7: After reset `out_valid` is low and `acc_q` is zero. An accepted request raises `out_valid` at the next edge with its result.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, `out_result` and `out_valid` hold, and offered requests are not taken. A reduce offered then does not touch the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 2 | 00 lane add, 01 widening multiply, 10 scalar add, 11 reduce |
| in_sat | input | 1 | Clamp add lanes on overflow instead of wrapping |
| in_a | input | 64 | Packed operand A, four 16-bit lanes |
| in_b | input | 64 | Packed operand B, four 16-bit lanes |
| in_scalar | input | 16 | Scalar broadcast for scalar add |
| acc_clr | input | 1 | Synchronous accumulator clear |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 128 | Registered result |
| acc_q | output | 40 | Accumulator value |

## Verification
The stream checks assume that a producer does not withdraw or change anything on its side except at clock edges, and that `in_op` always carries one of the four defined codes. Since two bits leave no undefined code, the second point holds by width. The bench drives all inputs on falling edges and moves `in_valid` only between transactions. The stall check assumes that `out_ready` stays low for whole cycles, and the back-pressure sequence follows that. The accumulator stability check assumes that `acc_clr` is driven only as a single deliberate pulse. The bench raises it in just two isolated cycles.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    OP_VADD = 2'b00,
    OP_VMUL = 2'b01,
    OP_SADD = 2'b10,
    OP_HSUM = 2'b11
  } simd_op_e;
endpackage

// File: rtl/simd_lane_add.sv
// One lane of signed addition, wrapping or clamping on overflow.
module simd_lane_add #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic              sat,
  output logic [LANE_W-1:0] y
);
  logic [LANE_W:0] sum_ext;
  logic            ovf;

  always_comb begin
    sum_ext = {a[LANE_W-1], a} + {b[LANE_W-1], b};
    ovf     = sum_ext[LANE_W] ^ sum_ext[LANE_W-1];
    if (sat && ovf) begin
      // sign of the true sum is the extra top bit
      y = sum_ext[LANE_W] ? {1'b1, {(LANE_W-1){1'b0}}} : {1'b0, {(LANE_W-1){1'b1}}};
    end else begin
      y = sum_ext[LANE_W-1:0];
    end
  end
endmodule

// File: rtl/simd_vec_add.sv
// Packed add: lane-wise or with a scalar broadcast into every lane.
module simd_vec_add #(
  parameter int LANES  = 4,
  parameter int LANE_W = 16,
  localparam int VEC_W = LANES * LANE_W
) (
  input  logic [VEC_W-1:0]  vec_a,
  input  logic [VEC_W-1:0]  vec_b,
  input  logic [LANE_W-1:0] scalar,
  input  logic              bcast,
  input  logic              sat,
  output logic [VEC_W-1:0]  vec_y
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] rhs;
    assign rhs = bcast ? scalar : vec_b[k*LANE_W +: LANE_W];
    simd_lane_add #(.LANE_W(LANE_W)) add_i (
      .a  (vec_a[k*LANE_W +: LANE_W]),
      .b  (rhs),
      .sat(sat),
      .y  (vec_y[k*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/simd_vec_mul.sv
// Widening signed multiply, each lane product in a double-width slot.
module simd_vec_mul #(
  parameter int LANES  = 4,
  parameter int LANE_W = 16,
  localparam int VEC_W  = LANES * LANE_W,
  localparam int PROD_W = 2 * LANE_W
) (
  input  logic [VEC_W-1:0]       vec_a,
  input  logic [VEC_W-1:0]       vec_b,
  output logic [2*VEC_W-1:0]     vec_y
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [LANE_W-1:0] sa;
    logic signed [LANE_W-1:0] sb;
    logic signed [PROD_W-1:0] prod;
    assign sa   = vec_a[k*LANE_W +: LANE_W];
    assign sb   = vec_b[k*LANE_W +: LANE_W];
    assign prod = PROD_W'(sa) * PROD_W'(sb);
    assign vec_y[k*PROD_W +: PROD_W] = prod;
  end
endmodule

// File: rtl/simd_hsum.sv
// Horizontal signed sum of all lanes, widened so it never overflows.
module simd_hsum #(
  parameter int LANES  = 4,
  parameter int LANE_W = 16,
  localparam int VEC_W = LANES * LANE_W,
  localparam int SUM_W = LANE_W + $clog2(LANES)
) (
  input  logic [VEC_W-1:0] vec_a,
  output logic [SUM_W-1:0] sum
);
  always_comb begin
    logic [LANE_W-1:0] lane;
    sum = '0;
    for (int k = 0; k < LANES; k++) begin
      lane = vec_a[k*LANE_W +: LANE_W];
      sum  = sum + {{(SUM_W-LANE_W){lane[LANE_W-1]}}, lane};
    end
  end
endmodule

// File: rtl/simd_pack_alu.sv
module simd_pack_alu
  import simd_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 16,
  parameter int ACC_W  = 40,
  localparam int VEC_W = LANES * LANE_W,
  localparam int RES_W = 2 * VEC_W,
  localparam int SUM_W = LANE_W + $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic              in_sat,
  input  logic [VEC_W-1:0]  in_a,
  input  logic [VEC_W-1:0]  in_b,
  input  logic [LANE_W-1:0] in_scalar,
  input  logic              acc_clr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RES_W-1:0]  out_result,
  output logic [ACC_W-1:0]  acc_q
);
  simd_op_e           op;
  logic               take;
  logic [VEC_W-1:0]   add_y;
  logic [RES_W-1:0]   mul_y;
  logic [SUM_W-1:0]   hsum;
  logic [ACC_W-1:0]   acc_base;
  logic [ACC_W-1:0]   acc_next;
  logic [RES_W-1:0]   res_next;
  logic               red_take;

  assign op       = simd_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign red_take = take && (op == OP_HSUM);

  simd_vec_add #(.LANES(LANES), .LANE_W(LANE_W)) vadd_i (
    .vec_a (in_a),
    .vec_b (in_b),
    .scalar(in_scalar),
    .bcast (op == OP_SADD),
    .sat   (in_sat),
    .vec_y (add_y)
  );

  simd_vec_mul #(.LANES(LANES), .LANE_W(LANE_W)) vmul_i (
    .vec_a(in_a),
    .vec_b(in_b),
    .vec_y(mul_y)
  );

  simd_hsum #(.LANES(LANES), .LANE_W(LANE_W)) hsum_i (
    .vec_a(in_a),
    .sum  (hsum)
  );

  // Clear takes effect first, then an accepted reduction folds in.
  always_comb begin
    acc_base = acc_clr ? '0 : acc_q;
    acc_next = red_take ? acc_base + {{(ACC_W-SUM_W){hsum[SUM_W-1]}}, hsum} : acc_base;
  end

  always_comb begin
    unique case (op)
      OP_VADD, OP_SADD: res_next = {{(RES_W-VEC_W){1'b0}}, add_y};
      OP_VMUL:          res_next = mul_y;
      default:          res_next = {{(RES_W-ACC_W){acc_next[ACC_W-1]}}, acc_next};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      acc_q      <= '0;
    end else begin
      acc_q <= acc_next;
      if (take) begin
        out_valid  <= 1'b1;
        out_result <= res_next;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/simd_pack_alu_chk.sv
module simd_pack_alu_chk #(
  parameter int RES_W = 128,
  parameter int VEC_W = 64,
  parameter int ACC_W = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_op,
  input logic             acc_clr,
  input logic             out_valid,
  input logic             out_ready,
  input logic [RES_W-1:0] out_result,
  input logic [ACC_W-1:0] acc_q
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && acc_q == '0)) else $error("reset state"); // R7

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid) else $error("valid after accept"); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result))) else $error("stall hold"); // R8

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready) else $error("stall ready"); // R8

  AST_ACC_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!acc_clr && !(in_valid && in_ready && in_op == 2'b11)) |=> $stable(acc_q)) else $error("acc moved"); // R6

  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (acc_clr && !(in_valid && in_ready && in_op == 2'b11)) |=> (acc_q == '0)) else $error("acc clear"); // R6

  AST_ADD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_op[0]) |=> (out_result[RES_W-1:VEC_W] == '0)) else $error("upper half"); // R1
endmodule

bind simd_pack_alu simd_pack_alu_chk #(
  .RES_W(RES_W), .VEC_W(VEC_W), .ACC_W(ACC_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .acc_clr   (acc_clr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_result(out_result),
  .acc_q     (acc_q)
);

// File: tb/simd_pack_alu_tb.sv
module simd_pack_alu_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_op = 2'b00;
  logic         in_sat = 1'b0;
  logic [63:0]  in_a = '0;
  logic [63:0]  in_b = '0;
  logic [15:0]  in_scalar = '0;
  logic         acc_clr = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_result;
  logic [39:0]  acc_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [39:0] exp_acc = '0;

  always #2 clk = ~clk;

  simd_pack_alu dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_sat(in_sat), .in_a(in_a), .in_b(in_b),
    .in_scalar(in_scalar), .acc_clr(acc_clr), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .acc_q(acc_q)
  );

  localparam logic [15:0] VALS [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                                       16'h8000, 16'h4000, 16'hC001, 16'h1234};

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] e_add(input logic [15:0] a, input logic [15:0] b, input logic sat);
    int s;
    s = int'(shortint'(a)) + int'(shortint'(b));
    if (sat && s > 32767) s = 32767;
    if (sat && s < -32768) s = -32768;
    return s[15:0];
  endfunction

  function automatic logic [127:0] e_vec(input logic [1:0] op, input logic sat,
                                         input logic [63:0] a, input logic [63:0] b,
                                         input logic [15:0] s);
    logic [127:0] r;
    int p;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      if (op == 2'b01) begin
        p = int'(shortint'(a[16*k +: 16])) * int'(shortint'(b[16*k +: 16]));
        r[32*k +: 32] = p;
      end else begin
        r[16*k +: 16] = e_add(a[16*k +: 16], (op == 2'b10) ? s : b[16*k +: 16], sat);
      end
    end
    return r;
  endfunction

  function automatic logic [39:0] e_sum(input logic [63:0] a);
    int s;
    s = 0;
    for (int k = 0; k < 4; k++) s += int'(shortint'(a[16*k +: 16]));
    return 40'(signed'(s));
  endfunction

  task automatic xact(input logic [1:0] op, input logic sat, input logic [63:0] a,
                      input logic [63:0] b, input logic [15:0] s);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_sat = sat; in_a = a; in_b = b; in_scalar = s;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_red(input logic [63:0] a, input string req);
    xact(2'b11, 1'b0, a, '0, '0);
    exp_acc = exp_acc + e_sum(a);
    chk({req, " reduce acc"}, {88'b0, acc_q}, {88'b0, exp_acc});
    chk({req, " reduce result"}, out_result, {{88{exp_acc[39]}}, exp_acc});
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    logic [127:0] hold;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    chk("R7 reset out_valid", {127'b0, out_valid}, 128'd0);
    chk("R7 reset acc", {88'b0, acc_q}, 128'd0);
    chk("R7 reset in_ready", {127'b0, in_ready}, 128'd1);

    // R1 R2 R3 R4 sweep over corner lane values
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        a = {VALS[(j+3)%8], VALS[(i+1)%8], VALS[j], VALS[i]};
        b = {VALS[(i+5)%8], VALS[(j+2)%8], VALS[i], VALS[j]};
        for (int m = 0; m < 5; m++) begin
          logic [1:0] op;
          logic sat;
          op  = (m < 2) ? 2'b00 : (m < 4) ? 2'b10 : 2'b01;
          sat = m[0];
          xact(op, sat, a, b, VALS[(i+j)%8]);
          chk("R7 out_valid", {127'b0, out_valid}, 128'd1);
          if (op == 2'b01)      chk("R4 widening multiply", out_result, e_vec(op, sat, a, b, VALS[(i+j)%8]));
          else if (op == 2'b10) chk("R3 scalar add", out_result, e_vec(op, sat, a, b, VALS[(i+j)%8]));
          else if (sat)         chk("R2 saturating add", out_result, e_vec(op, sat, a, b, '0));
          else                  chk("R1 wrapping add", out_result, e_vec(op, sat, a, b, '0));
        end
      end
    end
    // R2 explicit clamp lanes
    xact(2'b00, 1'b1, {16'h0001, 16'h8000, 16'h7FFF, 16'h7000},
                      {16'h0002, 16'hFFFF, 16'h0001, 16'h7000}, '0);
    chk("R2 clamp", out_result, {64'b0, 16'h0003, 16'h8000, 16'h7FFF, 16'h7FFF});

    // R5 reductions accumulate
    for (int i = 0; i < 8; i++)
      run_red({VALS[i], VALS[(i+2)%8], VALS[(i+4)%8], VALS[(i+6)%8]}, "R5");
    run_red({4{16'h8000}}, "R5");
    run_red({4{16'h7FFF}}, "R5");

    // R6 clear alone
    @(negedge clk); acc_clr = 1'b1;
    @(negedge clk); acc_clr = 1'b0; exp_acc = '0;
    chk("R6 clear", {88'b0, acc_q}, 128'd0);
    run_red({4{16'h8000}}, "R6");
    // R6 clear with simultaneous reduce
    @(negedge clk);
    acc_clr = 1'b1; in_valid = 1'b1; in_op = 2'b11; in_a = {16'h0005, 16'h0006, 16'hFFFF, 16'h0001};
    @(negedge clk);
    acc_clr = 1'b0; in_valid = 1'b0;
    exp_acc = 40'd11;
    chk("R6 clear plus reduce", {88'b0, acc_q}, {88'b0, exp_acc});

    // R8 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 2'b00; in_sat = 1'b0;
    in_a = 64'h0001_0002_0003_0004; in_b = 64'h0010_0020_0030_0040;
    @(negedge clk);
    hold = {64'b0, 64'h0011_0022_0033_0044};
    in_op = 2'b11; in_a = {4{16'h0100}};
    @(negedge clk);
    chk("R8 stalled valid", {127'b0, out_valid}, 128'd1);
    chk("R8 stalled ready", {127'b0, in_ready}, 128'd0);
    chk("R8 stalled result", out_result, hold);
    @(negedge clk);
    chk("R8 held result", out_result, hold);
    chk("R8 acc untouched", {88'b0, acc_q}, {88'b0, exp_acc});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp_acc = exp_acc + 40'h400;
    chk("R8 resumed reduce", out_result, {88'b0, exp_acc});
    chk("R8 resumed acc", {88'b0, acc_q}, {88'b0, exp_acc});
    @(negedge clk);
    chk("R7 drained", {127'b0, out_valid}, 128'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule